// File: doc/BRIEF.md
# Interrupt Line to Message Controller

This block gathers 64 wired interrupt inputs and turns them into vectored interrupt messages. Every input passes a two-flop synchronizer, then a per-line sense stage. Each line can be set to sense edges or levels, and either polarity. An edge line holds a latched event until software clears it or its message is taken. A level line asks for service while it sits at its active level.

Lines that are pending, not masked and allowed to send messages go to a fixed-priority picker, and the lowest line number wins. The winner is sent on a valid/ready channel as two bytes that software programs for that line: a vector byte and a route byte.

Software reaches all configuration through a simple 32-bit register port with byte enables. An identification word reports how many inputs the block has.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset every line is masked, no edge event is latched, the trigger, polarity and message-enable bits are zero, each vector byte equals its line index, each route byte is 1, and no message is valid.
- R2: Register access is word aligned (address bits 1:0 must be zero, or the access does nothing), and each byte enable selects one byte lane. Read data appears on reg_rdata_o in the cycle after the request. Per-line bits sit at word n/32, bit n%32, of pairs of words 4 bytes apart: mask at 0x20, message enable at 0x40, trigger at 0x60, clear at 0x80, polarity at 0x3E0. The route byte of line n is at 0x100+n and its vector byte is at 0x200+n, in byte lane n%4.
- R3: Offset 0x004 reads the input count minus one in bits 23:16, which is 63 here. This field is bits 55:48 of the 64-bit word at offset 0. Offset 0, the clear words, the bounce words at 0xC0 and 0xE0, and every unmapped offset read zero.
- R4: Trigger bit 1 selects edge sensing and 0 selects level sensing. Polarity 0 selects rising or active-high, and 1 selects falling or active-low. An edge line latches a pending event on the selected transition of its synchronized input.
- R5: A level line is pending while active. Once its message is accepted it is not sent again until the input goes inactive and comes back, or until software writes the mask word that holds its bit.
- R6: A mask bit of 1, or a message-enable bit of 0, keeps a line from being sent. A latched edge is kept while the line is blocked and is sent once the line is unblocked.
- R7: Writing 1 to a clear bit discards that line's latched edge. Writing 0 has no effect. Clear writes do not affect level lines.
- R8: Among pending, unmasked, enabled lines the lowest index wins. The message carries that line's vector and route bytes.
- R9: The message payload stays stable while valid is high and ready is low. After an accept, valid is low for the next cycle, and the accepted edge line's latch is cleared.
- R10: The software start-up sequence leaves every line masked and no edge pending. That sequence writes all-ones to mask and clear, zero to both bounce words and all-ones to message enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Wired interrupt inputs, asynchronous |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte address |
| reg_be_i | input | 4 | Byte enables for writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the request |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted when high with valid |
| msg_vec_o | output | 8 | Vector byte of the winning line |
| msg_route_o | output | 8 | Route byte of the winning line |

## Verification
The hardest state to reach from the ports is a line that is pending but cannot be seen. Examples are an edge latched on a masked or disabled line, or a level line that has been served and is still held active. The pending state itself cannot be read, so the bench only learns about it from whether a message appears later. To reach it, the bench blocks a line, produces the event, applies a clear write or a mask write, and then unblocks the line. It then expects either a silent window or a message with the programmed vector. All four sense modes are swept over all 64 lines, each with distinct arithmetic vector and route bytes.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  // byte offsets of the register windows
  localparam int OFF_ID    = 'h004;
  localparam int OFF_MASK  = 'h020;
  localparam int OFF_EN    = 'h040;
  localparam int OFF_TRIG  = 'h060;
  localparam int OFF_CLR   = 'h080;
  localparam int OFF_ROUTE = 'h100;
  localparam int OFF_VEC   = 'h200;
  localparam int OFF_POL   = 'h3E0;
  localparam int BITS_PER_WORD = 32;
  localparam int BYTES_PER_WORD = 4;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff1_q, ff2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= '0;
      ff2_q <= '0;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end
  assign q_o = ff2_q;
endmodule

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] rearm_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic act, prev_q, latch_q, armed_q;
    assign act = line_i[g] ^ pol_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
        armed_q <= 1'b1;
      end else begin
        prev_q <= act;
        // a new edge wins over a same-cycle clear
        if (trig_i[g] && act && !prev_q) latch_q <= 1'b1;
        else if (clr_i[g] || ack_i[g] || !trig_i[g]) latch_q <= 1'b0;
        if (ack_i[g] && !trig_i[g]) armed_q <= 1'b0;
        else if (!act || rearm_i[g]) armed_q <= 1'b1;
      end
    end

    assign pend_o[g] = trig_i[g] ? latch_q : (act & armed_q);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 reg_req_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [3:0]           reg_be_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic [7:0]           msg_vec_o,
  output logic [7:0]           msg_route_o
);
  localparam int NW    = NUM_LINES / BITS_PER_WORD;
  localparam int NBW   = NUM_LINES / BYTES_PER_WORD;
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int WA_W  = ADDR_W - 2;
  localparam logic [7:0] ID_CNT = 8'(NUM_LINES - 1);

  logic [NUM_LINES-1:0] mask_q, en_q, trig_q, pol_q;
  logic [NUM_LINES-1:0][7:0] vec_q, route_q;
  logic [NUM_LINES-1:0] sync_s, pend, req_vec, clr_vec, rearm_vec, ack_vec;
  logic [WA_W-1:0] wa;
  logic acc, wr;
  logic any;
  logic [IDX_W-1:0] win;
  logic msg_valid_q;
  logic [IDX_W-1:0] msg_line_q;
  logic [7:0] msg_vec_q, msg_route_q;
  logic [31:0] rd_mux, rdata_q;

  assign wa  = reg_addr_i[ADDR_W-1:2];
  assign acc = reg_req_i && (reg_addr_i[1:0] == 2'b00);
  assign wr  = acc && reg_we_i;

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      en_q   <= '0;
      trig_q <= '0;
      pol_q  <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        vec_q[i]   <= 8'(i);
        route_q[i] <= 8'd1;
      end
    end else if (wr) begin
      for (int w = 0; w < NW; w++) begin
        for (int b = 0; b < 4; b++) begin
          if (reg_be_i[b]) begin
            if (wa == WA_W'(OFF_MASK / 4 + w)) mask_q[w*32+b*8 +: 8] <= reg_wdata_i[b*8 +: 8];
            if (wa == WA_W'(OFF_EN / 4 + w))   en_q[w*32+b*8 +: 8]   <= reg_wdata_i[b*8 +: 8];
            if (wa == WA_W'(OFF_TRIG / 4 + w)) trig_q[w*32+b*8 +: 8] <= reg_wdata_i[b*8 +: 8];
            if (wa == WA_W'(OFF_POL / 4 + w))  pol_q[w*32+b*8 +: 8]  <= reg_wdata_i[b*8 +: 8];
          end
        end
      end
      for (int w = 0; w < NBW; w++) begin
        for (int b = 0; b < 4; b++) begin
          if (reg_be_i[b]) begin
            if (wa == WA_W'(OFF_ROUTE / 4 + w)) route_q[w*4+b] <= reg_wdata_i[b*8 +: 8];
            if (wa == WA_W'(OFF_VEC / 4 + w))   vec_q[w*4+b]   <= reg_wdata_i[b*8 +: 8];
          end
        end
      end
    end
  end

  // write-side strobes: clear pulses and level re-arm on mask write
  always_comb begin
    clr_vec   = '0;
    rearm_vec = '0;
    for (int w = 0; w < NW; w++) begin
      if (wr && wa == WA_W'(OFF_MASK / 4 + w)) rearm_vec[w*32 +: 32] = '1;
      for (int b = 0; b < 4; b++) begin
        if (wr && reg_be_i[b] && wa == WA_W'(OFF_CLR / 4 + w))
          clr_vec[w*32+b*8 +: 8] = reg_wdata_i[b*8 +: 8];
      end
    end
  end

  always_comb begin
    ack_vec = '0;
    ack_vec[msg_line_q] = msg_valid_q && msg_ready_i;
  end

  irq_sync #(.W(NUM_LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (sync_s)
  );

  irq_sense #(.N(NUM_LINES)) u_sense (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (sync_s),
    .trig_i (trig_q),
    .pol_i  (pol_q),
    .clr_i  (clr_vec),
    .ack_i  (ack_vec),
    .rearm_i(rearm_vec),
    .pend_o (pend)
  );

  assign req_vec = pend & ~mask_q & en_q;

  irq_pick #(.N(NUM_LINES)) u_pick (
    .req_i(req_vec),
    .any_o(any),
    .idx_o(win)
  );

  // message register; one idle cycle after each accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_q <= 1'b0;
      msg_line_q  <= '0;
      msg_vec_q   <= '0;
      msg_route_q <= '0;
    end else if (msg_valid_q) begin
      if (msg_ready_i) msg_valid_q <= 1'b0;
    end else if (any) begin
      msg_valid_q <= 1'b1;
      msg_line_q  <= win;
      msg_vec_q   <= vec_q[win];
      msg_route_q <= route_q[win];
    end
  end

  assign msg_valid_o = msg_valid_q;
  assign msg_vec_o   = msg_vec_q;
  assign msg_route_o = msg_route_q;

  // read path
  always_comb begin
    rd_mux = '0;
    if (wa == WA_W'(OFF_ID / 4)) rd_mux[23:16] = ID_CNT;
    for (int w = 0; w < NW; w++) begin
      if (wa == WA_W'(OFF_MASK / 4 + w)) rd_mux = mask_q[w*32 +: 32];
      if (wa == WA_W'(OFF_EN / 4 + w))   rd_mux = en_q[w*32 +: 32];
      if (wa == WA_W'(OFF_TRIG / 4 + w)) rd_mux = trig_q[w*32 +: 32];
      if (wa == WA_W'(OFF_POL / 4 + w))  rd_mux = pol_q[w*32 +: 32];
    end
    for (int w = 0; w < NBW; w++) begin
      for (int b = 0; b < 4; b++) begin
        if (wa == WA_W'(OFF_ROUTE / 4 + w)) rd_mux[b*8 +: 8] = route_q[w*4+b];
        if (wa == WA_W'(OFF_VEC / 4 + w))   rd_mux[b*8 +: 8] = vec_q[w*4+b];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (acc && !reg_we_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/irq_msg_ctrl_chk.sv
module irq_msg_ctrl_chk #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ready_i,
  input logic [7:0]       vec_i,
  input logic [7:0]       route_i,
  input logic [IDX_W-1:0] line_i,
  input logic [N-1:0]     req_i,
  input logic [N-1:0]     mask_i,
  input logic [N-1:0]     en_i
);
  logic [N-1:0] req_d, mask_d, en_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d  <= '0;
      mask_d <= '1;
      en_d   <= '0;
    end else begin
      req_d  <= req_i;
      mask_d <= mask_i;
      en_d   <= en_i;
    end
  end

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> valid_i && $stable(vec_i) && $stable(route_i));

  assert_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_i |=> !valid_i);

  assert_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> !mask_d[line_i] && en_d[line_i]);

  assert_lowest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> req_d[line_i] && ((req_d & ((N'(1) << line_i) - N'(1))) == '0));
endmodule

bind irq_msg_ctrl irq_msg_ctrl_chk #(.N(NUM_LINES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(msg_valid_o),
  .ready_i(msg_ready_i),
  .vec_i  (msg_vec_o),
  .route_i(msg_route_o),
  .line_i (msg_line_q),
  .req_i  (req_vec),
  .mask_i (mask_q),
  .en_i   (en_q)
);

// File: tb/tb_irq_msg_ctrl.sv
module tb_irq_msg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] lines = '0;
  logic req = 1'b0, we = 1'b0, ready = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0] be = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic valid;
  logic [7:0] vec, route;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_msg_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(lines),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_be_i(be),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .msg_valid_o(valid), .msg_ready_i(ready), .msg_vec_o(vec), .msg_route_o(route)
  );

  function automatic logic [7:0] vecf(int i);
    return 8'(255 - 3 * i);
  endfunction
  function automatic logic [7:0] routef(int i);
    return 8'(7 * i + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d, input logic [3:0] e = 4'hF);
    req = 1; we = 1; addr = a; wdata = d; be = e;
    @(negedge clk);
    req = 0; we = 0; be = 4'hF;
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd32(a, d);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic wait_msg(input logic [7:0] ev, input logic [7:0] er, input string tag);
    int n = 0;
    while (!valid && n < 12) begin
      @(negedge clk);
      n++;
    end
    chk(valid, {tag, " valid"}, valid, 1);
    if (valid) begin
      chk(vec == ev, {tag, " vector"}, vec, ev);
      chk(route == er, {tag, " route"}, route, er);
      @(negedge clk);
      chk(valid && vec == ev && route == er, "R9 payload held without ready", vec, ev);
      ready = 1;
      @(negedge clk);
      ready = 0;
      chk(!valid, "R9 valid low after accept", valid, 0);
    end
  endtask

  task automatic no_msg(input int cyc, input string tag);
    bit seen = 0;
    logic [7:0] v = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (valid && !seen) begin
        seen = 1;
        v = vec;
      end
    end
    chk(!seen, tag, v, 0);
  endtask

  task automatic cfg_mode(input bit t, input bit p);
    wr32(12'h020, '1); wr32(12'h024, '1);
    wr32(12'h060, {32{t}}); wr32(12'h064, {32{t}});
    wr32(12'h3E0, {32{p}}); wr32(12'h3E4, {32{p}});
    lines = {N{p}};
    repeat (5) @(negedge clk);
    wr32(12'h080, '1); wr32(12'h084, '1);
    wr32(12'h020, '0); wr32(12'h024, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(!valid, "R1 no message after reset", valid, 0);
    rd_chk(12'h020, 32'hFFFF_FFFF, "R1 mask word0 reset");
    rd_chk(12'h024, 32'hFFFF_FFFF, "R1 mask word1 reset");
    rd_chk(12'h040, 0, "R1 enable reset");
    rd_chk(12'h060, 0, "R1 trigger reset");
    rd_chk(12'h3E4, 0, "R1 polarity reset");
    for (int w = 0; w < 16; w++) begin
      logic [31:0] e;
      for (int b = 0; b < 4; b++) e[b*8 +: 8] = 8'(4 * w + b);
      rd_chk(12'(12'h200 + 4 * w), e, "R1 vector byte equals index");
      rd_chk(12'(12'h100 + 4 * w), 32'h0101_0101, "R1 route byte is one");
    end

    // R3 identification and zero reads
    rd_chk(12'h004, 32'h003F_0000, "R3 id count field");
    rd_chk(12'h000, 0, "R3 offset 0 low word");
    rd_chk(12'h300, 0, "R3 unmapped offset");

    // R10 start-up sequence
    wr32(12'h020, '1); wr32(12'h024, '1);
    wr32(12'h080, '1); wr32(12'h084, '1);
    wr32(12'h0C0, 0); wr32(12'h0C4, 0); wr32(12'h0E0, 0); wr32(12'h0E4, 0);
    wr32(12'h040, '1); wr32(12'h044, '1);
    rd_chk(12'h024, 32'hFFFF_FFFF, "R10 mask all set");
    rd_chk(12'h0C0, 0, "R10 bounce word reads zero (R3)");
    rd_chk(12'h084, 0, "R3 clear word reads zero");
    rd_chk(12'h044, 32'hFFFF_FFFF, "R10 enable all set");
    no_msg(4, "R10 nothing pending after sequence");

    // R2 byte lanes, alignment, vector/route programming
    wr32(12'h060, 32'hAABB_CCDD, 4'b0101);
    rd_chk(12'h060, 32'h00BB_00DD, "R2 byte enables select lanes");
    wr32(12'h062, 32'hFFFF_FFFF);
    rd_chk(12'h060, 32'h00BB_00DD, "R2 misaligned write ignored");
    wr32(12'h060, 0);
    for (int w = 0; w < 16; w++) begin
      logic [31:0] dv, dr;
      for (int b = 0; b < 4; b++) begin
        dv[b*8 +: 8] = vecf(4 * w + b);
        dr[b*8 +: 8] = routef(4 * w + b);
      end
      wr32(12'(12'h200 + 4 * w), dv);
      wr32(12'(12'h100 + 4 * w), dr);
      rd_chk(12'(12'h200 + 4 * w), dv, "R2 vector readback");
      rd_chk(12'(12'h100 + 4 * w), dr, "R2 route readback");
    end

    // R4 R5 R8: sweep all sense modes over all lines
    for (int m = 0; m < 4; m++) begin
      bit t = m[1];
      bit p = m[0];
      cfg_mode(t, p);
      for (int i = 0; i < N; i++) begin
        lines[i] = ~p;
        if (t) begin
          repeat (3) @(negedge clk);
          lines[i] = p;
          wait_msg(vecf(i), routef(i), "R4 edge line message");
          no_msg(5, "R9 edge latch cleared on accept");
        end else begin
          wait_msg(vecf(i), routef(i), "R4 level line message");
          no_msg(5, "R5 level not resent while held");
          lines[i] = p;
          repeat (4) @(negedge clk);
        end
      end
    end

    // R8 priority among simultaneous level lines
    cfg_mode(0, 0);
    lines[40] = 1; lines[9] = 1; lines[5] = 1;
    wait_msg(vecf(5), routef(5), "R8 lowest first");
    wait_msg(vecf(9), routef(9), "R8 second lowest");
    wait_msg(vecf(40), routef(40), "R8 highest last");
    lines = '0;
    repeat (4) @(negedge clk);

    // R7 clear on edge lines
    cfg_mode(1, 0);
    wr32(12'h020, 32'h0000_0008);
    lines[3] = 1; repeat (3) @(negedge clk); lines[3] = 0;
    repeat (3) @(negedge clk);
    wr32(12'h080, 32'h0000_0008);
    wr32(12'h020, 0);
    no_msg(6, "R7 cleared edge not sent");
    wr32(12'h020, 32'h0000_0010);
    lines[4] = 1; repeat (3) @(negedge clk); lines[4] = 0;
    repeat (3) @(negedge clk);
    wr32(12'h080, 32'hFFFF_FFEF);
    no_msg(3, "R6 masked edge held back");
    wr32(12'h020, 0);
    wait_msg(vecf(4), routef(4), "R7 zero clear bit keeps edge");

    // R6 message enable gating
    wr32(12'h040, 32'hFFFF_FFFE);
    lines[0] = 1; repeat (3) @(negedge clk); lines[0] = 0;
    no_msg(6, "R6 disabled line not sent");
    wr32(12'h040, '1);
    wait_msg(vecf(0), routef(0), "R6 latched edge sent after enable");

    // R7 clear ignores level lines; R5 re-arm by mask write
    cfg_mode(0, 0);
    wr32(12'h020, 32'h0000_0040);
    lines[6] = 1;
    repeat (4) @(negedge clk);
    wr32(12'h080, 32'h0000_0040);
    wr32(12'h020, 0);
    wait_msg(vecf(6), routef(6), "R7 level unaffected by clear");
    no_msg(4, "R5 level held not resent");
    wr32(12'h020, 0);
    wait_msg(vecf(6), routef(6), "R5 mask write re-arms level");
    lines[6] = 0;
    repeat (4) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule